// File: doc/BRIEF.md
# Four-Phase Time-Multiplexed Bus Master

This block drives one shared set of bus lines that carries address, transfer direction and data in turn. Each transfer fills a fixed frame of four clock cycles, T1 to T4. The address goes out in T1. A direction code goes out in T2. Data moves in T3 and T4. On a write the master keeps driving through the frame. On a read it releases the lines after T2 so that the selected slave can drive them.

A user-side port offers one request at a time: an address, a write flag and write data. The request is taken while the master is idle. When a frame ends, the master raises a one-cycle done pulse, and for a read it presents the word it captured from the bus. The bus is modelled as three separate signals: a value the master drives, an output enable and a value read back. The tristate pad itself sits outside this block.

Top module: `tmux_bus_master`

## Requirements
- R1: After reset, `phase` is 0 (idle), `bus_oe` is 0, `done` is 0 and `req_ready` is 1. With no request pending, the master stays idle and does not drive the bus.
- R2: `phase` uses the encoding 0 = idle, 1 = T1, 2 = T2, 3 = T3, 4 = T4. A request accepted in an idle cycle (`req_valid` and `req_ready` both high) gives T1 in the next cycle. T2, T3 and T4 then follow, one per clock, and the master returns to idle after T4.
- R3: During T1, `bus_oe` is 1 and `bus_out` equals the accepted address.
- R4: During T2, `bus_oe` is 1 and `bus_out` carries the direction code: value 1 for a write and value 0 for a read.
- R5: For a write, `bus_oe` is 1 during both T3 and T4, and `bus_out` equals the accepted write data in both phases.
- R6: For a read, `bus_oe` is 0 during T3 and T4. `rd_data` takes the value of `bus_in` sampled at the clock edge that ends T4. A value on `bus_in` during T3 has no effect on `rd_data`.
- R7: `done` is high for exactly the one cycle that follows T4. `req_ready` is high only while `phase` is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | W | Transfer address |
| req_wdata | input | W | Write data |
| req_ready | output | 1 | Master idle; request taken this cycle if valid |
| rd_data | output | W | Captured read data |
| done | output | 1 | One-cycle end-of-frame pulse |
| phase | output | 3 | Frame phase (0 idle, 1..4 = T1..T4) |
| bus_out | output | W | Value driven onto the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| bus_in | input | W | Value sensed on the shared lines |

## Verification
On every cycle, the bound checker checks several things. It checks that the phase moves forward one step per clock and returns to idle after T4. It checks that the master stays idle without a request and drives the bus in T1 and T2. It checks that the master releases the bus in T3 and T4 after a read code, and that `done` is a single-cycle pulse placed right after T4. The bench scenarios are needed for the values themselves. They show the address and write data on the lines, and a captured read word that matches the T4 value and not the different T3 value. They also cover back-to-back frames, mixed directions, and all-zero and all-one addresses.

// File: rtl/tmux_bus_master.sv
module tmux_bus_master #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_wdata,
  output logic         req_ready,
  output logic [W-1:0] rd_data,
  output logic         done,
  output logic [2:0]   phase,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  input  logic [W-1:0] bus_in
);

  localparam logic [2:0] P_IDLE = 3'd0;
  localparam logic [2:0] P_T1   = 3'd1;
  localparam logic [2:0] P_T2   = 3'd2;
  localparam logic [2:0] P_T3   = 3'd3;
  localparam logic [2:0] P_T4   = 3'd4;

  logic [W-1:0] addr_q, wdata_q;
  logic         wr_q;
  logic         data_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      done    <= 1'b0;
      rd_data <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        P_IDLE: if (req_valid) begin
          phase   <= P_T1;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
        end
        P_T1: phase <= P_T2;
        P_T2: phase <= P_T3;
        P_T3: phase <= P_T4;
        P_T4: begin
          phase <= P_IDLE;
          done  <= 1'b1;
          if (!wr_q) rd_data <= bus_in;
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  assign req_ready = (phase == P_IDLE);
  assign data_ph   = (phase == P_T3) || (phase == P_T4);
  assign bus_oe    = (phase == P_T1) || (phase == P_T2) || (data_ph && wr_q);

  always_comb begin
    case (phase)
      P_T1:       bus_out = addr_q;
      P_T2:       bus_out = {{(W-1){1'b0}}, wr_q};
      P_T3, P_T4: bus_out = wr_q ? wdata_q : '0;
      default:    bus_out = '0;
    endcase
  end

endmodule

module tmux_bus_master_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic [2:0]   phase,
  input logic         done,
  input logic         bus_oe,
  input logic [W-1:0] bus_out
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && !req_valid) |=> (phase == 3'd0 && !bus_oe)); // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase inside {3'd1, 3'd2, 3'd3}) |=> (phase == $past(phase) + 3'd1)); // R2
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4) |=> (phase == 3'd0 && done)); // R2
  AST_ADDR_DIR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 || phase == 3'd2) |-> bus_oe); // R3
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2 && bus_out[0] == 1'b0) |=> (!bus_oe ##1 !bus_oe)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(phase) == 3'd4)); // R7

endmodule

bind tmux_bus_master tmux_bus_master_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .phase(phase),
  .done(done), .bus_oe(bus_oe), .bus_out(bus_out)
);

// File: tb/tmux_bus_master_tb_top.sv
module tmux_bus_master_tb_top;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [W-1:0] RD_KEY = 16'hA5C3;
  localparam logic [W-1:0] T3_JUNK = 16'h0F0F;

  typedef struct packed {
    logic         wr;
    logic [W-1:0] addr;
    logic [W-1:0] data;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [W-1:0] req_addr = '0, req_wdata = '0;
  logic req_ready, done, bus_oe;
  logic [W-1:0] rd_data, bus_out, bus_in, slv_addr;
  logic [2:0] phase;
  int n_chk = 0, n_fail = 0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmux_bus_master #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .done(done), .phase(phase), .bus_out(bus_out),
    .bus_oe(bus_oe), .bus_in(bus_in)
  );

  assign bus_in = (phase == 3'd4) ? (slv_addr ^ RD_KEY) : T3_JUNK;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [W-1:0] a, input logic [W-1:0] d);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    it.wr = wr; it.addr = a; it.data = d;
    sb.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  logic [2:0] prev_ph = 3'd0;
  logic prev_acc = 0;
  logic mon_on = 0;
  always @(negedge clk) if (mon_on) begin
    if (prev_ph inside {3'd1, 3'd2, 3'd3}) check("R2 step", {13'd0, phase}, {13'd0, prev_ph + 3'd1});
    if (prev_acc) check("R2 start", {13'd0, phase}, 16'd1);
    check("R7 done timing", {15'd0, done}, {15'd0, prev_ph == 3'd4});
    check("R7 ready", {15'd0, req_ready}, {15'd0, phase == 3'd0});
    if (sb.size() != 0) begin
      case (phase)
        3'd1: begin
          slv_addr = bus_out;
          check("R3 oe", {15'd0, bus_oe}, 16'd1);
          check("R3 addr", bus_out, sb[0].addr);
        end
        3'd2: begin
          check("R4 oe", {15'd0, bus_oe}, 16'd1);
          check("R4 dir", bus_out, {15'd0, sb[0].wr});
        end
        3'd3, 3'd4: if (sb[0].wr) begin
          check("R5 oe", {15'd0, bus_oe}, 16'd1);
          check("R5 data", bus_out, sb[0].data);
        end else check("R6 release", {15'd0, bus_oe}, 16'd0);
        default: ;
      endcase
      if (done) begin
        if (!sb[0].wr) check("R6 rd_data", rd_data, sb[0].addr ^ RD_KEY);
        void'(sb.pop_front());
      end
    end
    prev_acc = req_valid && req_ready;
    prev_ph = phase;
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check("R1 phase", {13'd0, phase}, 16'd0);
        check("R1 oe", {15'd0, bus_oe}, 16'd0);
        check("R1 done", {15'd0, done}, 16'd0);
        check("R1 ready", {15'd0, req_ready}, 16'd1);
        mon_on = 1;
        for (int i = 0; i < 5; i++) begin
          @(negedge clk);
          check("R1 idle", {12'd0, bus_oe, phase}, 16'd0);
        end
        xfer(1, 16'h1234, 16'hBEEF);
        xfer(0, 16'h1234, 16'h0);
        xfer(0, 16'h0000, 16'h0);
        xfer(1, 16'hFFFF, 16'h0000);
        xfer(1, 16'h0000, 16'hFFFF);
        xfer(0, 16'hFFFF, 16'h0);
        for (int i = 0; i < 8; i++) xfer(i[0], 16'(i * 16'h1111), 16'(~(i * 16'h0707)));
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule